// File: doc/BRIEF.md
# CPU Interrupt Input Latch

This block sits between the interrupt request pins of a small processor and the sequencer of its core. It brings a maskable request, a non-maskable request, a poll level, seven external controller request lines and the output of an on-chip timer channel into the core's clock domain. From them it keeps three pieces of state for the sequencer: a maskable-request pending flag, a non-maskable-request pending flag and a halted flag. The sequencer reads the pending flags to decide when to take an interrupt, raises a one-cycle strobe to enter halt, and raises a one-cycle strobe to acknowledge a non-maskable request it has taken.

A static strap selects the source of the maskable request. In direct mode the request comes from a dedicated pin. In integrated mode that pin is not used. Instead, the request is the output of an eight-input interrupt controller. Input 0 of that controller is tied inside the chip to timer channel 0, and inputs 1 to 7 come from the external request lines. In this block the controller output is the OR of its eight inputs, because priority resolution and vectoring belong to the controller proper.

Two small state machines hold the state. The run machine has the states RUN_ST and HALT_ST. The transition "enter halt" goes RUN_ST to HALT_ST when halt is requested and no wake condition is present. The transition "wake" goes HALT_ST to RUN_ST on an asserted maskable source or a non-maskable rising edge. The NMI machine has the states NMI_IDLE and NMI_HELD. The transition "latch" goes NMI_IDLE to NMI_HELD on a rising edge. The transition "acknowledge" goes NMI_HELD to NMI_IDLE on the acknowledge strobe when no new edge arrives in the same cycle. A rising edge that arrives while the NMI machine is already in NMI_HELD leaves it in NMI_HELD.

Top module: `cpu_irq_latch`

## Requirements
- R1: After reset, `int_pend`, `nmi_pend`, `halted` and `poll_lvl` are 0, and the stored non-maskable level is deasserted.
- R2: `int_pend` equals the selected maskable source level. A change on the source pin appears on `int_pend` after the third rising clock edge (two synchronizer flops plus the flag register).
- R3: A one-cycle `halt_req` sets `halted` at the next rising edge, unless a wake condition is present in that cycle. `halted` then stays 1 until a wake condition occurs.
- R4: While the selected maskable source is asserted, `halted` is cleared, and this takes priority over `halt_req`.
- R5: A change of the synchronized `nmi_pin` from 0 to 1 sets `nmi_pend` and clears `halted`. A sample equal to the stored level has no effect, so holding `nmi_pin` high after an acknowledge does not set `nmi_pend` again.
- R6: Deasserting `nmi_pin` never clears `nmi_pend`. Only `nmi_ack` clears it, at the next rising edge.
- R7: When a non-maskable rising edge and `nmi_ack` fall in the same cycle, `nmi_pend` remains 1.
- R8: `poll_lvl` shows `poll_pin` after two rising edges and has no effect on `int_pend`, `nmi_pend` or `halted`.
- R9: With `integ_mode` = 1, `int_pin` is ignored and the maskable source is the OR of controller inputs 0 to 7. Inputs 1 to 7 are `ir_pins[7:1]`.
- R10: With `integ_mode` = 1, controller input 0 is `tmr0_out`, so the timer alone asserts `int_pend`.
- R11: With `integ_mode` = 0, `ir_pins` and `tmr0_out` are ignored, and they neither set `int_pend` nor wake a halted core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| integ_mode | input | 1 | Static strap: 1 selects the controller output as the maskable source |
| int_pin | input | 1 | Direct maskable request, asynchronous, active high |
| nmi_pin | input | 1 | Non-maskable request, asynchronous, active high |
| poll_pin | input | 1 | Poll level, asynchronous |
| ir_pins | input | 7 | External controller request lines 1 to 7, asynchronous |
| tmr0_out | input | 1 | Timer channel 0 output, tied to controller input 0 |
| halt_req | input | 1 | One-cycle strobe from the core to enter halt |
| nmi_ack | input | 1 | One-cycle strobe from the core to clear the NMI pending flag |
| int_pend | output | 1 | Maskable request pending |
| nmi_pend | output | 1 | Non-maskable request pending |
| halted | output | 1 | Core is halted |
| poll_lvl | output | 1 | Synchronized poll level |

## Verification
The bench checks the exact latency of the synchronizer path. A design with one stage too few or too many would report the flag a cycle early or late. It keeps `nmi_pin` high across an acknowledge and then drops it while a request is pending. A design that treated NMI as level-sensitive would either set the flag again or lose a request that had not yet been taken. It places the acknowledge strobe in the same cycle as a fresh rising edge, where a design that let the acknowledge win would drop an interrupt. It also drives each mode with the other mode's request sources: the dedicated pin in integrated mode, and the controller lines and timer in direct mode. A routing mistake would then raise a request that should be ignored, or would fail to wake a halted core.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // Run machine: the core executes, or waits in halt for a wake condition.
    typedef enum logic {
        RUN_ST  = 1'b0,
        HALT_ST = 1'b1
    } run_state_e;

    // Non-maskable request machine: nothing pending, or a latched edge.
    typedef enum logic {
        NMI_IDLE = 1'b0,
        NMI_HELD = 1'b1
    } nmi_state_e;

    // Positions of the single-bit asynchronous inputs inside the synchronizer bus.
    localparam int unsigned SIG_INT  = 0;
    localparam int unsigned SIG_NMI  = 1;
    localparam int unsigned SIG_POLL = 2;
    localparam int unsigned SIG_TMR  = 3;
    localparam int unsigned SIG_IR0  = 4;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else begin
                    if (s == 0) begin
                        chain_q[s] <= async_i;
                    end else begin
                        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                    end
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int unsigned NUM_IR = 8
) (
    input  logic              integ_mode,
    input  logic              direct_int,
    input  logic              tmr0,
    input  logic [NUM_IR-1:1] ext_ir,
    output logic              int_src
);

    // Request vector seen by the on-chip controller.
    logic [NUM_IR-1:0] ctl_req;
    logic              ctl_out;

    generate
        for (genvar i = 0; i < NUM_IR; i++) begin : g_req
            if (i == 0) begin : g_timer
                // Input 0 is tied to the timer channel inside the chip.
                assign ctl_req[i] = tmr0;
            end else begin : g_pin
                assign ctl_req[i] = ext_ir[i];
            end
        end
    endgenerate

    assign ctl_out = |ctl_req;

    always_comb begin
        if (integ_mode) begin
            int_src = ctl_out;
        end else begin
            int_src = direct_int;
        end
    end

endmodule

// File: rtl/irq_flag_fsm.sv
module irq_flag_fsm
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic int_src,
    input  logic nmi_lvl,
    input  logic halt_req,
    input  logic nmi_ack,
    output logic int_pend,
    output logic nmi_pend,
    output logic halted,
    output logic nmi_rise
);

    run_state_e run_q, run_d;
    nmi_state_e nmi_q, nmi_d;
    logic       nmi_prev_q;
    logic       int_pend_q;
    logic       wake;

    // A sample equal to the stored level produces no edge.
    assign nmi_rise = nmi_lvl & ~nmi_prev_q;
    assign wake     = int_src | nmi_rise;

    // Next state of both machines.
    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_ST: begin
                if (halt_req && !wake) begin
                    run_d = HALT_ST;
                end
            end
            HALT_ST: begin
                if (wake) begin
                    run_d = RUN_ST;
                end
            end
            default: run_d = RUN_ST;
        endcase

        nmi_d = nmi_q;
        unique case (nmi_q)
            NMI_IDLE: begin
                if (nmi_rise) begin
                    nmi_d = NMI_HELD;
                end
            end
            NMI_HELD: begin
                // A fresh edge in the same cycle beats the acknowledge.
                if (nmi_ack && !nmi_rise) begin
                    nmi_d = NMI_IDLE;
                end
            end
            default: nmi_d = NMI_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= RUN_ST;
            nmi_q      <= NMI_IDLE;
            nmi_prev_q <= 1'b0;
            int_pend_q <= 1'b0;
        end else begin
            run_q      <= run_d;
            nmi_q      <= nmi_d;
            nmi_prev_q <= nmi_lvl;
            int_pend_q <= int_src;
        end
    end

    // Outputs.
    always_comb begin
        int_pend = int_pend_q;
        halted   = 1'b0;
        nmi_pend = 1'b0;
        unique case (run_q)
            RUN_ST:  halted = 1'b0;
            HALT_ST: halted = 1'b1;
            default: halted = 1'b0;
        endcase
        unique case (nmi_q)
            NMI_IDLE: nmi_pend = 1'b0;
            NMI_HELD: nmi_pend = 1'b1;
            default:  nmi_pend = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu_irq_latch.sv
module cpu_irq_latch
    import irq_latch_pkg::*;
#(
    parameter int unsigned NUM_IR      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              integ_mode,
    input  logic              int_pin,
    input  logic              nmi_pin,
    input  logic              poll_pin,
    input  logic [NUM_IR-1:1] ir_pins,
    input  logic              tmr0_out,
    input  logic              halt_req,
    input  logic              nmi_ack,
    output logic              int_pend,
    output logic              nmi_pend,
    output logic              halted,
    output logic              poll_lvl
);

    localparam int unsigned EXT_IR = NUM_IR - 1;
    localparam int unsigned SYNC_W = SIG_IR0 + EXT_IR;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              int_src;
    logic              nmi_rise;

    always_comb begin
        raw_bus           = '0;
        raw_bus[SIG_INT]  = int_pin;
        raw_bus[SIG_NMI]  = nmi_pin;
        raw_bus[SIG_POLL] = poll_pin;
        raw_bus[SIG_TMR]  = tmr0_out;
        raw_bus[SYNC_W-1:SIG_IR0] = ir_pins;
    end

    irq_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (sync_bus)
    );

    irq_router #(
        .NUM_IR (NUM_IR)
    ) router_i (
        .integ_mode (integ_mode),
        .direct_int (sync_bus[SIG_INT]),
        .tmr0       (sync_bus[SIG_TMR]),
        .ext_ir     (sync_bus[SYNC_W-1:SIG_IR0]),
        .int_src    (int_src)
    );

    irq_flag_fsm flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_src  (int_src),
        .nmi_lvl  (sync_bus[SIG_NMI]),
        .halt_req (halt_req),
        .nmi_ack  (nmi_ack),
        .int_pend (int_pend),
        .nmi_pend (nmi_pend),
        .halted   (halted),
        .nmi_rise (nmi_rise)
    );

    assign poll_lvl = sync_bus[SIG_POLL];

endmodule

// File: rtl/cpu_irq_latch_chk.sv
module cpu_irq_latch_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_req,
    input logic nmi_ack,
    input logic int_src,
    input logic nmi_rise,
    input logic int_pend,
    input logic nmi_pend,
    input logic halted
);

    p_int_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_pend == $past(int_src));

    p_halt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !int_src && !nmi_rise) |=> halted);

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !int_src && !nmi_rise) |=> halted);

    p_int_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int_src |=> !halted);

    p_nmi_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_rise |=> (nmi_pend && !halted));

    p_nmi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_pend && !nmi_rise) |=> !nmi_pend);

    p_nmi_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !nmi_ack) |=> nmi_pend);

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack && !nmi_rise) |=> !nmi_pend);

    p_edge_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack && nmi_rise) |=> nmi_pend);

endmodule

bind cpu_irq_latch cpu_irq_latch_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_req (halt_req),
    .nmi_ack  (nmi_ack),
    .int_src  (int_src),
    .nmi_rise (nmi_rise),
    .int_pend (int_pend),
    .nmi_pend (nmi_pend),
    .halted   (halted)
);

// File: tb/cpu_irq_latch_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       integ_mode = 1'b0;
    logic       int_pin = 1'b0;
    logic       nmi_pin = 1'b0;
    logic       poll_pin = 1'b0;
    logic [7:1] ir_pins = '0;
    logic       tmr0_out = 1'b0;
    logic       halt_req = 1'b0;
    logic       nmi_ack = 1'b0;
    logic       int_pend, nmi_pend, halted, poll_lvl;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cpu_irq_latch dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .integ_mode (integ_mode),
        .int_pin    (int_pin),
        .nmi_pin    (nmi_pin),
        .poll_pin   (poll_pin),
        .ir_pins    (ir_pins),
        .tmr0_out   (tmr0_out),
        .halt_req   (halt_req),
        .nmi_ack    (nmi_ack),
        .int_pend   (int_pend),
        .nmi_pend   (nmi_pend),
        .halted     (halted),
        .poll_lvl   (poll_lvl)
    );

    task automatic check(input string req, input string what,
                         input logic actual, input logic expected);
        tests_run++;
        if (actual !== expected) begin
            tests_failed++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, actual, expected);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_halt();
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 1'b0;
    endtask

    task automatic pulse_ack();
        nmi_ack = 1'b1;
        @(negedge clk);
        nmi_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "int_pend after reset", int_pend, 1'b0);
        check("R1", "nmi_pend after reset", nmi_pend, 1'b0);
        check("R1", "halted after reset", halted, 1'b0);
        check("R1", "poll_lvl after reset", poll_lvl, 1'b0);
    endtask

    task automatic t_int_level();
        int_pin = 1'b1;
        cycles(2);
        check("R2", "int_pend before third edge", int_pend, 1'b0);
        cycles(1);
        check("R2", "int_pend after third edge", int_pend, 1'b1);
        int_pin = 1'b0;
        cycles(3);
        check("R2", "int_pend follows deassert", int_pend, 1'b0);
    endtask

    task automatic t_halt_wake();
        pulse_halt();
        check("R3", "halted after strobe", halted, 1'b1);
        cycles(5);
        check("R3", "halted held", halted, 1'b1);
        int_pin = 1'b1;
        cycles(3);
        check("R4", "int wakes core", halted, 1'b0);
        pulse_halt();
        check("R4", "int beats halt_req", halted, 1'b0);
        int_pin = 1'b0;
        cycles(4);
    endtask

    task automatic t_nmi_edge();
        pulse_halt();
        nmi_pin = 1'b1;
        cycles(3);
        check("R5", "nmi_pend on rising edge", nmi_pend, 1'b1);
        check("R5", "nmi edge wakes core", halted, 1'b0);
        pulse_ack();
        check("R6", "ack clears nmi_pend", nmi_pend, 1'b0);
        cycles(5);
        check("R5", "held level ignored", nmi_pend, 1'b0);
        nmi_pin = 1'b0;
        cycles(4);
        nmi_pin = 1'b1;
        cycles(3);
        check("R5", "second edge sets pend", nmi_pend, 1'b1);
        nmi_pin = 1'b0;
        cycles(5);
        check("R6", "deassert keeps pend", nmi_pend, 1'b1);
        pulse_ack();
        check("R6", "ack clears pend", nmi_pend, 1'b0);
        cycles(2);
    endtask

    task automatic t_nmi_race();
        nmi_pin = 1'b1;
        cycles(2);
        nmi_ack = 1'b1;
        @(negedge clk);
        nmi_ack = 1'b0;
        check("R7", "edge wins over ack", nmi_pend, 1'b1);
        pulse_ack();
        nmi_pin = 1'b0;
        cycles(4);
        check("R7", "cleanup pend", nmi_pend, 1'b0);
    endtask

    task automatic t_poll();
        pulse_halt();
        poll_pin = 1'b1;
        cycles(1);
        check("R8", "poll before second edge", poll_lvl, 1'b0);
        cycles(1);
        check("R8", "poll after second edge", poll_lvl, 1'b1);
        cycles(3);
        check("R8", "poll leaves int_pend", int_pend, 1'b0);
        check("R8", "poll leaves nmi_pend", nmi_pend, 1'b0);
        check("R8", "poll leaves halted", halted, 1'b1);
        poll_pin = 1'b0;
        int_pin = 1'b1;
        cycles(4);
        int_pin = 1'b0;
        cycles(4);
    endtask

    task automatic t_integrated();
        integ_mode = 1'b1;
        cycles(2);
        int_pin = 1'b1;
        cycles(4);
        check("R9", "int_pin ignored in integrated", int_pend, 1'b0);
        int_pin = 1'b0;
        ir_pins = 7'b0010000;
        cycles(4);
        check("R9", "ir line 5 raises int", int_pend, 1'b1);
        ir_pins = 7'b1000000;
        cycles(4);
        check("R9", "ir line 7 raises int", int_pend, 1'b1);
        ir_pins = '0;
        cycles(4);
        check("R9", "controller idle clears int", int_pend, 1'b0);
        tmr0_out = 1'b1;
        cycles(4);
        check("R10", "timer on input 0 raises int", int_pend, 1'b1);
        tmr0_out = 1'b0;
        cycles(4);
        check("R10", "timer release clears int", int_pend, 1'b0);
    endtask

    task automatic t_direct();
        integ_mode = 1'b0;
        cycles(2);
        pulse_halt();
        ir_pins = 7'b1111111;
        tmr0_out = 1'b1;
        cycles(4);
        check("R11", "controller lines ignored", int_pend, 1'b0);
        check("R11", "no wake from ignored lines", halted, 1'b1);
        ir_pins = '0;
        tmr0_out = 1'b0;
        int_pin = 1'b1;
        cycles(4);
        check("R11", "direct pin raises int", int_pend, 1'b1);
        int_pin = 1'b0;
        cycles(4);
    endtask

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_int_level();
        t_halt_wake();
        t_nmi_edge();
        t_nmi_race();
        t_poll();
        t_integrated();
        t_direct();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule